// File: doc/BRIEF.md
# Delay-Cycle Trigger Sequencer

This block opens a timing cycle of a digital delay generator. It takes an external trigger that has already been converted to a logic level. It also takes four control bits: external select, polarity, internal trigger and inhibit. A flop that is clocked directly by the selected trigger net captures the active edge without waiting for the reference clock. The captured state drives a busy flag, which software can read to see that a cycle is running. It also opens a jitter-measurement pulse. The analog jitter correction uses the width of that pulse to recover the sub-period offset between the trigger and the reference clock.

The capture feeds a two-stage shift register clocked on the rising edge of the reference clock. The nominal reference is 80 MHz, with a 12.5 ns period. The two stages are held as the states of a small machine:

- `S_IDLE` (00): waiting for a trigger.
- `S_ALIGN` (01): the first stage holds the capture.
- `S_RUN` (11): the second stage holds it.

The machine has these transitions:

- `S_IDLE`→`S_ALIGN` happens on the first reference edge that sees the capture.
- `S_ALIGN`→`S_RUN` happens on the next reference edge.
- Any state→`S_IDLE` happens on an edge where the cycle-clear input is high.

On entry to `S_RUN`, the jitter pulse ends and the count enables of five channels (T0, A, B, C, D) rise together. Further triggers are ignored until the cycle is cleared.

Top module: `trg_sequencer`

## Requirements
- R1: With `ext_sel`=1 and `pol`=0, a falling edge on `ext_in` raises `busy` at once, without waiting for a clock edge.
- R2: With `ext_sel`=1 and `pol`=1, a rising edge on `ext_in` starts a cycle, and a falling edge does not.
- R3: With `ext_sel`=0, `ext_in` has no effect. A single falling edge of `int_trig` starts one cycle, and a rising edge of `int_trig` starts none.
- R4: A trigger edge that arrives while `inhibit`=1 starts no cycle: `busy`, `jitter` and `run_en` stay 0.
- R5: Once set, `busy` stays 1 until the first reference edge at which `cyc_clear` is sampled high. It goes to 0 right after that edge.
- R6: `jitter` is 1 from the capture until the reference edge that enters `S_RUN`, and 0 at every other time.
- R7: All five bits of `run_en` (bit 0 = T0, then A, B, C, D) rise together on the second rising reference edge after the capture. They are never partly set.
- R8: On a reference edge where `cyc_clear` is sampled 1, the machine returns to `S_IDLE` and all of `run_en` goes to 0.
- R9: Trigger edges that arrive while `busy`=1 are not remembered: after the clear, `busy` stays 0.
- R10: While `rst_n`=0, and after its release with no trigger, `busy`, `jitter` and `run_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference count clock (nominally 80 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External trigger after the discriminator |
| ext_sel | input | 1 | 1 = external trigger path, 0 = internal trigger bit |
| pol | input | 1 | 1 = rising edges of `ext_in` trigger, 0 = falling edges |
| int_trig | input | 1 | Internal trigger / single-shot bit; its falling edge triggers when `ext_sel`=0 |
| inhibit | input | 1 | 1 blocks every trigger |
| cyc_clear | input | 1 | Synchronous end-of-cycle clear |
| busy | output | 1 | Timing cycle in progress |
| jitter | output | 1 | Pulse from the trigger to the edge that enables counting |
| run_en | output | 5 | Channel count enables, bit 0 = T0, bits 1..4 = A..D |

## Verification
The assertions take for granted that `ext_sel`, `pol` and `int_trig` change only in one of two ways. They change while `inhibit` is high, or as the intended trigger edge. Otherwise a change of selection could itself form a capture edge. They also assume that `cyc_clear` is a clean pulse that is synchronous to the reference clock. The stimulus changes the configuration only under inhibit and then releases it. It drives every trigger edge a quarter of a period away from the reference edges, and it drives `cyc_clear` only at falling clock edges.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int unsigned NCH = 5;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_ALIGN = 2'b01,
        S_RUN   = 2'b11
    } seq_state_t;
endpackage

// File: rtl/trg_edge_capture.sv
module trg_edge_capture (
    input  logic ext_in,
    input  logic ext_sel,
    input  logic pol,
    input  logic int_trig,
    input  logic inhibit,
    input  logic cap_rst,
    output logic captured
);
    logic sel_net;
    logic fire;

    // External path inverted by polarity; internal bit used when not selected.
    assign sel_net = ext_sel ? (ext_in ^ pol) : int_trig;
    // A falling edge of the selected net is the active trigger.
    assign fire = ~sel_net;

    always_ff @(posedge fire or posedge cap_rst) begin
        if (cap_rst) begin
            captured <= 1'b0;
        end else if (!inhibit) begin
            captured <= 1'b1;
        end
    end
endmodule

// File: rtl/trg_sync_fsm.sv
module trg_sync_fsm
    import trg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       captured,
    input  logic       clear,
    output seq_state_t state,
    output logic       clear_q
);
    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (clear) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_nx = captured ? S_ALIGN : S_IDLE;
                S_ALIGN: state_nx = captured ? S_RUN : S_IDLE;
                S_RUN:   state_nx = S_RUN;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            clear_q <= 1'b0;
        end else begin
            state   <= state_nx;
            clear_q <= clear;
        end
    end
endmodule

// File: rtl/trg_chan_gate.sv
module trg_chan_gate #(
    parameter int unsigned NCH = 5
) (
    input  logic           run,
    output logic [NCH-1:0] en
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign en[i] = run;
    end
endmodule

// File: rtl/trg_sequencer.sv
module trg_sequencer
    import trg_pkg::*;
#(
    parameter int unsigned CH = NCH
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          ext_in,
    input  logic          ext_sel,
    input  logic          pol,
    input  logic          int_trig,
    input  logic          inhibit,
    input  logic          cyc_clear,
    output logic          busy,
    output logic          jitter,
    output logic [CH-1:0] run_en
);
    logic       captured;
    logic       clear_q;
    logic       cap_rst;
    logic       run;
    seq_state_t state;

    assign cap_rst = ~rst_n | clear_q;

    trg_edge_capture u_cap (
        .ext_in   (ext_in),
        .ext_sel  (ext_sel),
        .pol      (pol),
        .int_trig (int_trig),
        .inhibit  (inhibit),
        .cap_rst  (cap_rst),
        .captured (captured)
    );

    trg_sync_fsm u_fsm (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .captured (captured),
        .clear    (cyc_clear),
        .state    (state),
        .clear_q  (clear_q)
    );

    always_comb begin
        run    = 1'b0;
        busy   = captured;
        jitter = 1'b0;
        unique case (state)
            S_IDLE:  jitter = captured;
            S_ALIGN: jitter = captured;
            S_RUN:   run    = 1'b1;
            default: run    = 1'b0;
        endcase
    end

    trg_chan_gate #(.NCH(CH)) u_gate (
        .run (run),
        .en  (run_en)
    );
endmodule

// File: rtl/trg_sequencer_chk.sv
module trg_sequencer_chk #(
    parameter int unsigned CH = 5
) (
    input logic          ref_clk,
    input logic          rst_n,
    input logic          cyc_clear,
    input logic          busy,
    input logic          jitter,
    input logic [CH-1:0] run_en
);
    // R7
    lockstep_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($countones(run_en) == 0) || ($countones(run_en) == CH));

    // R7
    start_after_busy_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(run_en[0]) |-> $past(busy));

    // R6
    jitter_off_in_run_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        run_en[0] |-> !jitter);

    // R6
    jitter_needs_busy_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        jitter |-> busy);

    // R5
    busy_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (busy && !cyc_clear) |=> busy);

    // R8
    clear_stop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cyc_clear |=> (run_en == '0));
endmodule

bind trg_sequencer trg_sequencer_chk #(.CH(CH)) u_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .cyc_clear (cyc_clear),
    .busy      (busy),
    .jitter    (jitter),
    .run_en    (run_en)
);

// File: tb/sim_trg_sequencer.sv
`timescale 1ns/1ps
module sim_trg_sequencer;
    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic       ext_sel = 1'b0;
    logic       pol = 1'b0;
    logic       int_trig = 1'b1;
    logic       inhibit = 1'b1;
    logic       cyc_clear = 1'b0;
    logic       busy;
    logic       jitter;
    logic [4:0] run_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 ref_clk = ~ref_clk;

    trg_sequencer u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .ext_in(ext_in), .ext_sel(ext_sel),
        .pol(pol), .int_trig(int_trig), .inhibit(inhibit), .cyc_clear(cyc_clear),
        .busy(busy), .jitter(jitter), .run_en(run_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input bit b, input bit j, input logic [4:0] e);
        check(busy == b, {req, " busy"}, busy, b);
        check(jitter == j, {req, " jitter"}, jitter, j);
        check(run_en == e, {req, " run_en"}, run_en, e);
    endtask

    // Configure under inhibit, then release inhibit; leaves us just after a negedge.
    task automatic configure(input bit es, input bit p, input bit ei, input bit it);
        @(negedge ref_clk);
        inhibit = 1'b1;
        #0.5;
        ext_sel = es; pol = p; ext_in = ei; int_trig = it;
        #0.5;
        inhibit = 1'b0;
        @(negedge ref_clk);
    endtask

    task automatic clear_cycle();
        @(negedge ref_clk);
        cyc_clear = 1'b1;
        @(negedge ref_clk);
        cyc_clear = 1'b0;
        @(negedge ref_clk);
    endtask

    // Full cycle sequence check after a trigger driven 1 ns after a negedge.
    task automatic follow_cycle(input string req);
        #0.5;
        chk_out({req, " capture"}, 1'b1, 1'b1, 5'h00);
        @(negedge ref_clk);
        chk_out({req, " R6 align"}, 1'b1, 1'b1, 5'h00);
        @(negedge ref_clk);
        chk_out({req, " R7 run"}, 1'b1, 1'b0, 5'h1f);
        @(negedge ref_clk);
        chk_out({req, " R5 hold"}, 1'b1, 1'b0, 5'h1f);
    endtask

    task automatic t_reset();
        chk_out("R10 in reset", 1'b0, 1'b0, 5'h00);
        @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        @(negedge ref_clk);
        chk_out("R10 after release", 1'b0, 1'b0, 5'h00);
    endtask

    task automatic t_ext_fall();
        configure(1'b1, 1'b0, 1'b1, 1'b1);
        #1 ext_in = 1'b0;
        follow_cycle("R1");
        clear_cycle();
        chk_out("R8 after clear", 1'b0, 1'b0, 5'h00);
    endtask

    task automatic t_ext_rise_pol1();
        configure(1'b1, 1'b1, 1'b1, 1'b1);
        #1 ext_in = 1'b0;
        @(negedge ref_clk);
        @(negedge ref_clk);
        chk_out("R2 wrong edge", 1'b0, 1'b0, 5'h00);
        #1 ext_in = 1'b1;
        follow_cycle("R2");
        clear_cycle();
    endtask

    task automatic t_ext_rise_pol0_ignored();
        configure(1'b1, 1'b0, 1'b0, 1'b1);
        #1 ext_in = 1'b1;
        @(negedge ref_clk);
        @(negedge ref_clk);
        chk_out("R1 rising with pol0", 1'b0, 1'b0, 5'h00);
    endtask

    task automatic t_internal();
        configure(1'b0, 1'b0, 1'b1, 1'b1);
        #1 ext_in = 1'b0;
        @(negedge ref_clk);
        chk_out("R3 ext ignored", 1'b0, 1'b0, 5'h00);
        #1 int_trig = 1'b0;
        follow_cycle("R3 single shot");
        clear_cycle();
        #1 int_trig = 1'b1;
        @(negedge ref_clk);
        @(negedge ref_clk);
        chk_out("R3 rising int", 1'b0, 1'b0, 5'h00);
    endtask

    task automatic t_inhibit();
        configure(1'b0, 1'b0, 1'b0, 1'b1);
        inhibit = 1'b1;
        #1 int_trig = 1'b0;
        @(negedge ref_clk);
        @(negedge ref_clk);
        @(negedge ref_clk);
        chk_out("R4 inhibited", 1'b0, 1'b0, 5'h00);
        inhibit = 1'b0;
    endtask

    task automatic t_busy_ignore();
        configure(1'b1, 1'b0, 1'b1, 1'b1);
        #1 ext_in = 1'b0;
        @(negedge ref_clk);
        #1 ext_in = 1'b1;
        @(negedge ref_clk);
        #1 ext_in = 1'b0;
        @(negedge ref_clk);
        chk_out("R9 still running", 1'b1, 1'b0, 5'h1f);
        clear_cycle();
        @(negedge ref_clk);
        chk_out("R9 not remembered", 1'b0, 1'b0, 5'h00);
    endtask

    initial begin
        #1;
        t_reset();
        t_ext_fall();
        t_ext_rise_pol1();
        t_ext_rise_pol0_ignored();
        t_internal();
        t_inhibit();
        t_busy_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule